// File: doc/BRIEF.md
# Flash Command Register Window

This block is the device-side register window of a flash-style memory. A host reaches it through a simple synchronous register bus with a byte address, a 16-bit write word, a write strobe, a read strobe and a registered read word. The window returns a fixed four-word signature and identity words. It holds the parameters of the next command: code, data, a split address and a split byte count. A write of 0x0001 to the execute register launches a modelled operation.

The operation engine is behavioural. Every accepted operation keeps the device busy for a fixed, parameterised number of cycles. The engine keeps a per-block lock table, applies its checks when the operation completes, and records errors in a status word. That word mixes read-only condition bits with sticky error bits that software clears. Program and erase operations can be suspended and later resumed. The memory array, voltage sensing and one-time-programmable contents are not modelled.

Top module: `flash_cmd_window`

## Requirements
- R1: After reset the status word at byte offset 0xCC reads 0x8080: bit 15 (available) is 1, bit 7 (ready) is 1, and every other bit is 0, including bits 3, 4 and 5, which no modelled operation sets. The command registers read 0x0000 and every block is unlocked.
- R2: A read strobe returns data on `bus_rdata` one cycle later, and the value is held until the next read strobe. The read-only words are: signature words 0 to 3 at offsets 0x00, 0x02, 0x04 and 0x06; manufacturer ID at 0x20; device ID at 0x22; program-buffer location at 0x40; program-buffer size in words at 0x42.
- R3: The command code (0x80), command data (0x84), address low (0x88), address high (0x8A), count low (0x90) and count high (0x92) registers latch whole 16-bit writes and read back what was written.
- R4: Writing exactly 0x0001 to offset 0xC0 while idle starts the operation named by the command code. Status bit 7 then reads 0 for BUSY_CYCLES cycles. Any other value written to 0xC0 has no effect.
- R5: An execute strobe is ignored while an operation is counting down. While an operation is suspended, only the resume command is accepted.
- R6: The target block is the low log2(NUM_BLOCKS) bits of the address high register. On completion, lock (0x61) marks the block locked, unlock (0x62) marks it unlocked, and read-lock-status (0x65) loads the command data register with 0x0001 if the block is locked and 0x0000 if it is not.
- R7: A program (0x41, 0xE9, 0xC0) or erase (0x20) whose target block is locked sets sticky status bit 1 on completion and changes nothing else.
- R8: Word program 0x41 with address-low bit 0 set, aimed at an unlocked block, sets status bits 9:8 to 11 on completion.
- R9: Executing a code outside the set {0x41, 0xE9, 0x20, 0x61, 0x62, 0x65, 0x98, 0x97, 0xC0, 0xD0} while idle sets sticky status bit 12 in the next cycle. The device does not go busy.
- R10: Writing 0x0001 to offset 0xC8 during a running program sets status bit 2, or during a running erase sets bit 6. The countdown freezes and bit 7 reads 1. Other values, and suspend requests during other operations, are ignored.
- R11: Executing 0xD0 while suspended clears bits 2 and 6 and resumes the countdown from the cycles that remain. Executing 0xD0 when nothing is suspended has no effect.
- R12: A write to offset 0xCC clears bit 1 where bit 1 of the written word is 1 and bit 12 where bit 12 is 1. Bits 9:8 clear to 00 where either of them is written 1. Read-only bits ignore the write. A sticky set and a clear in the same cycle leave the bit set.
- R13: Writing 0x0001 to offset 0xC4 zeroes the command data and both count registers. Any other value has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 16 | Write word |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read word |

## Verification
Two events can land in the same cycle: the engine setting a sticky error bit at the end of an operation, and a host write clearing that same bit. The bench provokes this by counting cycles from an execute strobe aimed at a locked block. It then writes 0x0002 to the status register exactly in the completion cycle. The following status read must still show bit 1 set. A later, separate clear must then remove it, which shows that the set won the collision and not that the clear path is broken.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  localparam int WORD_W = 16;

  // register byte offsets
  localparam logic [7:0] OFF_SIG0    = 8'h00;
  localparam logic [7:0] OFF_SIG1    = 8'h02;
  localparam logic [7:0] OFF_SIG2    = 8'h04;
  localparam logic [7:0] OFF_SIG3    = 8'h06;
  localparam logic [7:0] OFF_MFR     = 8'h20;
  localparam logic [7:0] OFF_DEV     = 8'h22;
  localparam logic [7:0] OFF_PBLOC   = 8'h40;
  localparam logic [7:0] OFF_PBSIZE  = 8'h42;
  localparam logic [7:0] OFF_CODE    = 8'h80;
  localparam logic [7:0] OFF_DATA    = 8'h84;
  localparam logic [7:0] OFF_ADDR_LO = 8'h88;
  localparam logic [7:0] OFF_ADDR_HI = 8'h8A;
  localparam logic [7:0] OFF_CNT_LO  = 8'h90;
  localparam logic [7:0] OFF_CNT_HI  = 8'h92;
  localparam logic [7:0] OFF_EXEC    = 8'hC0;
  localparam logic [7:0] OFF_CLRBUF  = 8'hC4;
  localparam logic [7:0] OFF_SUSP    = 8'hC8;
  localparam logic [7:0] OFF_STAT    = 8'hCC;

  localparam logic [WORD_W-1:0] TRIGGER_VAL = 16'h0001;

  // operation codes
  localparam logic [WORD_W-1:0] OP_WPROG   = 16'h0041;
  localparam logic [WORD_W-1:0] OP_BPROG   = 16'h00E9;
  localparam logic [WORD_W-1:0] OP_ERASE   = 16'h0020;
  localparam logic [WORD_W-1:0] OP_LOCK    = 16'h0061;
  localparam logic [WORD_W-1:0] OP_UNLOCK  = 16'h0062;
  localparam logic [WORD_W-1:0] OP_RDLOCK  = 16'h0065;
  localparam logic [WORD_W-1:0] OP_QUERY   = 16'h0098;
  localparam logic [WORD_W-1:0] OP_OTPRD   = 16'h0097;
  localparam logic [WORD_W-1:0] OP_OTPPROG = 16'h00C0;
  localparam logic [WORD_W-1:0] OP_RESUME  = 16'h00D0;

  // status bit positions
  localparam int SB_PROT    = 1;
  localparam int SB_PSUSP   = 2;
  localparam int SB_VLOW    = 3;
  localparam int SB_PERR    = 4;
  localparam int SB_EERR    = 5;
  localparam int SB_ESUSP   = 6;
  localparam int SB_READY   = 7;
  localparam int SB_REG_LO  = 8;
  localparam int SB_AUX     = 12;
  localparam int SB_AVAIL   = 15;

  function automatic logic op_is_prog(input logic [WORD_W-1:0] c);
    return (c == OP_WPROG) || (c == OP_BPROG) || (c == OP_OTPPROG);
  endfunction

  function automatic logic op_is_erase(input logic [WORD_W-1:0] c);
    return (c == OP_ERASE);
  endfunction

  function automatic logic op_known(input logic [WORD_W-1:0] c);
    return op_is_prog(c) || op_is_erase(c) || (c == OP_LOCK) ||
           (c == OP_UNLOCK) || (c == OP_RDLOCK) || (c == OP_QUERY) ||
           (c == OP_OTPRD) || (c == OP_RESUME);
  endfunction

endpackage

// File: rtl/fcw_cmd_regs.sv
module fcw_cmd_regs
  import fcw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              eng_data_we,
  input  logic [WORD_W-1:0] eng_data,
  output logic [WORD_W-1:0] code_o,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] addr_lo_o,
  output logic [WORD_W-1:0] addr_hi_o,
  output logic [WORD_W-1:0] cnt_lo_o,
  output logic [WORD_W-1:0] cnt_hi_o,
  output logic              exec_go_o,
  output logic              susp_go_o,
  output logic              stat_wr_o
);

  logic [WORD_W-1:0] code_q, data_q, alo_q, ahi_q, clo_q, chi_q;
  logic [WORD_W-1:0] code_d, data_d, alo_d, ahi_d, clo_d, chi_d;
  logic              is_trig, clrbuf_go;

  assign is_trig   = (bus_wdata == TRIGGER_VAL);
  assign exec_go_o = bus_we && (bus_addr == ADDR_W'(OFF_EXEC)) && is_trig;
  assign susp_go_o = bus_we && (bus_addr == ADDR_W'(OFF_SUSP)) && is_trig;
  assign clrbuf_go = bus_we && (bus_addr == ADDR_W'(OFF_CLRBUF)) && is_trig;
  assign stat_wr_o = bus_we && (bus_addr == ADDR_W'(OFF_STAT));

  always_comb begin
    code_d = code_q;
    data_d = data_q;
    alo_d  = alo_q;
    ahi_d  = ahi_q;
    clo_d  = clo_q;
    chi_d  = chi_q;
    if (bus_we) begin
      if (bus_addr == ADDR_W'(OFF_CODE))    code_d = bus_wdata;
      if (bus_addr == ADDR_W'(OFF_DATA))    data_d = bus_wdata;
      if (bus_addr == ADDR_W'(OFF_ADDR_LO)) alo_d  = bus_wdata;
      if (bus_addr == ADDR_W'(OFF_ADDR_HI)) ahi_d  = bus_wdata;
      if (bus_addr == ADDR_W'(OFF_CNT_LO))  clo_d  = bus_wdata;
      if (bus_addr == ADDR_W'(OFF_CNT_HI))  chi_d  = bus_wdata;
    end
    if (clrbuf_go) begin
      data_d = '0;
      clo_d  = '0;
      chi_d  = '0;
    end
    // engine result has priority over host writes to the data register
    if (eng_data_we) data_d = eng_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      data_q <= '0;
      alo_q  <= '0;
      ahi_q  <= '0;
      clo_q  <= '0;
      chi_q  <= '0;
    end else begin
      code_q <= code_d;
      data_q <= data_d;
      alo_q  <= alo_d;
      ahi_q  <= ahi_d;
      clo_q  <= clo_d;
      chi_q  <= chi_d;
    end
  end

  assign code_o    = code_q;
  assign data_o    = data_q;
  assign addr_lo_o = alo_q;
  assign addr_hi_o = ahi_q;
  assign cnt_lo_o  = clo_q;
  assign cnt_hi_o  = chi_q;

  // R13
  clrbuf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrbuf_go && !eng_data_we) |=> (data_q == '0 && clo_q == '0 && chi_q == '0));

endmodule

// File: rtl/fcw_engine.sv
module fcw_engine
  import fcw_pkg::*;
#(
  parameter int BUSY_CYCLES = 12,
  parameter int NUM_BLOCKS  = 16,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_go,
  input  logic              susp_go,
  input  logic [WORD_W-1:0] cmd_code,
  input  logic              odd_addr,
  input  logic [BLK_W-1:0]  blk_sel,
  output logic              ready,
  output logic              prog_susp,
  output logic              erase_susp,
  output logic              dps_set,
  output logic              rps_set,
  output logic              aos_set,
  output logic              rd_we,
  output logic [WORD_W-1:0] rd_val
);

  logic                  busy_q, busy_d;
  logic                  susp_q, susp_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [WORD_W-1:0]     op_q;
  logic [BLK_W-1:0]      blk_q;
  logic                  odd_q;
  logic [NUM_BLOCKS-1:0] lock_q, lock_d;

  logic op_start, op_resume, running, done, susp_ok, tgt_locked, is_pe;

  assign op_start   = exec_go && !busy_q && op_known(cmd_code) && (cmd_code != OP_RESUME);
  assign op_resume  = exec_go && busy_q && susp_q && (cmd_code == OP_RESUME);
  assign aos_set    = exec_go && !busy_q && !op_known(cmd_code);
  assign running    = busy_q && !susp_q;
  assign done       = running && (cnt_q == CNT_W'(1));
  assign is_pe      = op_is_prog(op_q) || op_is_erase(op_q);
  assign susp_ok    = susp_go && running && !done && is_pe;
  assign tgt_locked = lock_q[blk_q];

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    susp_d = susp_q;
    if (op_start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(BUSY_CYCLES);
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (running) begin
      cnt_d  = cnt_q - CNT_W'(1);
    end
    if (susp_ok)   susp_d = 1'b1;
    if (op_resume) susp_d = 1'b0;
  end

  // per-block lock cells, updated only when a lock or unlock completes
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_lock
    always_comb begin
      lock_d[g] = lock_q[g];
      if (done && (blk_q == BLK_W'(g))) begin
        if (op_q == OP_LOCK)   lock_d[g] = 1'b1;
        if (op_q == OP_UNLOCK) lock_d[g] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      susp_q <= 1'b0;
      cnt_q  <= '0;
      lock_q <= '0;
    end else begin
      busy_q <= busy_d;
      susp_q <= susp_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      blk_q <= '0;
      odd_q <= 1'b0;
    end else if (op_start) begin
      op_q  <= cmd_code;
      blk_q <= blk_sel;
      odd_q <= odd_addr;
    end
  end

  assign ready      = !running;
  assign prog_susp  = susp_q && op_is_prog(op_q);
  assign erase_susp = susp_q && op_is_erase(op_q);
  assign dps_set    = done && is_pe && tgt_locked;
  assign rps_set    = done && (op_q == OP_WPROG) && odd_q && !tgt_locked;
  assign rd_we      = done && (op_q == OP_RDLOCK);
  assign rd_val     = {{(WORD_W-1){1'b0}}, tgt_locked};

  // R5
  exec_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && exec_go) |=> $stable(op_q));

  // R10
  susp_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> busy_q);

  // R10
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_q && !op_resume) |=> $stable(cnt_q));

  // R4
  count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));

  // R6
  lock_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(lock_q));

endmodule

// File: rtl/fcw_status.sv
module fcw_status
  import fcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              prog_susp,
  input  logic              erase_susp,
  input  logic              dps_set,
  input  logic              rps_set,
  input  logic              aos_set,
  input  logic              clr_dps,
  input  logic              clr_rps,
  input  logic              clr_aos,
  output logic [WORD_W-1:0] stat_word
);

  logic       dps_q, dps_d;
  logic [1:0] rps_q, rps_d;
  logic       aos_q, aos_d;

  // a set arriving with a clear in the same cycle wins
  always_comb begin
    dps_d = dps_q;
    rps_d = rps_q;
    aos_d = aos_q;
    if (clr_dps) dps_d = 1'b0;
    if (clr_rps) rps_d = 2'b00;
    if (clr_aos) aos_d = 1'b0;
    if (dps_set) dps_d = 1'b1;
    if (rps_set) rps_d = 2'b11;
    if (aos_set) aos_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dps_q <= 1'b0;
      rps_q <= 2'b00;
      aos_q <= 1'b0;
    end else begin
      dps_q <= dps_d;
      rps_q <= rps_d;
      aos_q <= aos_d;
    end
  end

  always_comb begin
    stat_word                      = '0;
    stat_word[SB_AVAIL]            = 1'b1;
    stat_word[SB_READY]            = ready;
    stat_word[SB_PSUSP]            = prog_susp;
    stat_word[SB_ESUSP]            = erase_susp;
    stat_word[SB_PROT]             = dps_q;
    stat_word[SB_REG_LO +: 2]      = rps_q;
    stat_word[SB_AUX]              = aos_q;
    stat_word[SB_VLOW]             = 1'b0;
    stat_word[SB_PERR]             = 1'b0;
    stat_word[SB_EERR]             = 1'b0;
  end

  // R12
  sticky_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dps_set |=> dps_q);

  // R12
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_dps && !dps_set) |=> !dps_q);

  // R8
  region_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rps_set |=> (rps_q == 2'b11));

  // R9
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aos_q && !clr_aos) |=> aos_q);

endmodule

// File: rtl/flash_cmd_window.sv
module flash_cmd_window
  import fcw_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          BUSY_CYCLES = 12,
  parameter int          NUM_BLOCKS  = 16,
  parameter logic [63:0] SIGNATURE   = 64'h0057_0044_004D_0043,
  parameter logic [15:0] MFR_ID      = 16'h00A5,
  parameter logic [15:0] DEV_ID      = 16'h5A17,
  parameter logic [15:0] PBUF_LOC    = 16'h0400,
  parameter logic [15:0] PBUF_WORDS  = 16'h0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [15:0]       bus_rdata
);

  localparam int BLK_W = $clog2(NUM_BLOCKS);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WORD_W-1:0] code_w, data_w, alo_w, ahi_w, clo_w, chi_w;
  logic              exec_go, susp_go, stat_wr;
  logic              eng_ready, prog_susp, erase_susp;
  logic              dps_set, rps_set, aos_set, rd_we;
  logic [WORD_W-1:0] rd_val, stat_word;
  logic              clr_dps, clr_rps, clr_aos;

  fcw_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .eng_data_we(rd_we),
    .eng_data   (rd_val),
    .code_o     (code_w),
    .data_o     (data_w),
    .addr_lo_o  (alo_w),
    .addr_hi_o  (ahi_w),
    .cnt_lo_o   (clo_w),
    .cnt_hi_o   (chi_w),
    .exec_go_o  (exec_go),
    .susp_go_o  (susp_go),
    .stat_wr_o  (stat_wr)
  );

  fcw_engine #(.BUSY_CYCLES(BUSY_CYCLES), .NUM_BLOCKS(NUM_BLOCKS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .exec_go   (exec_go),
    .susp_go   (susp_go),
    .cmd_code  (code_w),
    .odd_addr  (alo_w[0]),
    .blk_sel   (ahi_w[BLK_W-1:0]),
    .ready     (eng_ready),
    .prog_susp (prog_susp),
    .erase_susp(erase_susp),
    .dps_set   (dps_set),
    .rps_set   (rps_set),
    .aos_set   (aos_set),
    .rd_we     (rd_we),
    .rd_val    (rd_val)
  );

  assign clr_dps = stat_wr && bus_wdata[SB_PROT];
  assign clr_rps = stat_wr && (bus_wdata[SB_REG_LO] || bus_wdata[SB_REG_LO+1]);
  assign clr_aos = stat_wr && bus_wdata[SB_AUX];

  fcw_status u_status (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ready     (eng_ready),
    .prog_susp (prog_susp),
    .erase_susp(erase_susp),
    .dps_set   (dps_set),
    .rps_set   (rps_set),
    .aos_set   (aos_set),
    .clr_dps   (clr_dps),
    .clr_rps   (clr_rps),
    .clr_aos   (clr_aos),
    .stat_word (stat_word)
  );

  logic [WORD_W-1:0] rd_mux, rdata_q;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_SIG0))    rd_mux = SIGNATURE[15:0];
    if (bus_addr == ADDR_W'(OFF_SIG1))    rd_mux = SIGNATURE[31:16];
    if (bus_addr == ADDR_W'(OFF_SIG2))    rd_mux = SIGNATURE[47:32];
    if (bus_addr == ADDR_W'(OFF_SIG3))    rd_mux = SIGNATURE[63:48];
    if (bus_addr == ADDR_W'(OFF_MFR))     rd_mux = MFR_ID;
    if (bus_addr == ADDR_W'(OFF_DEV))     rd_mux = DEV_ID;
    if (bus_addr == ADDR_W'(OFF_PBLOC))   rd_mux = PBUF_LOC;
    if (bus_addr == ADDR_W'(OFF_PBSIZE))  rd_mux = PBUF_WORDS;
    if (bus_addr == ADDR_W'(OFF_CODE))    rd_mux = code_w;
    if (bus_addr == ADDR_W'(OFF_DATA))    rd_mux = data_w;
    if (bus_addr == ADDR_W'(OFF_ADDR_LO)) rd_mux = alo_w;
    if (bus_addr == ADDR_W'(OFF_ADDR_HI)) rd_mux = ahi_w;
    if (bus_addr == ADDR_W'(OFF_CNT_LO))  rd_mux = clo_w;
    if (bus_addr == ADDR_W'(OFF_CNT_HI))  rd_mux = chi_w;
    if (bus_addr == ADDR_W'(OFF_STAT))    rd_mux = stat_word;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/flash_cmd_window_tb.sv
module flash_cmd_window_tb;

  localparam int B = 12;

  localparam logic [7:0] A_SIG0 = 8'h00, A_SIG1 = 8'h02, A_SIG2 = 8'h04, A_SIG3 = 8'h06;
  localparam logic [7:0] A_MFR = 8'h20, A_DEV = 8'h22, A_PBL = 8'h40, A_PBS = 8'h42;
  localparam logic [7:0] A_CODE = 8'h80, A_DATA = 8'h84, A_ALO = 8'h88, A_AHI = 8'h8A;
  localparam logic [7:0] A_CLO = 8'h90, A_CHI = 8'h92;
  localparam logic [7:0] A_EXEC = 8'hC0, A_CLRB = 8'hC4, A_SUSP = 8'hC8, A_STAT = 8'hCC;

  logic        clk, rst_n;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  flash_cmd_window #(.BUSY_CYCLES(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  // polls status; returns number of reads seen busy before ready
  task automatic poll(output int n);
    logic [15:0] v;
    bit fin;
    n = 0; fin = 0;
    for (int i = 0; i < 400 && !fin; i++) begin
      rd(A_STAT, v);
      if (v[7]) fin = 1;
      else n++;
    end
  endtask

  task automatic run_op(input logic [15:0] code, input logic [15:0] lo, input logic [15:0] hi);
    int n;
    wr(A_ALO, lo); wr(A_AHI, hi); wr(A_CODE, code); wr(A_EXEC, 16'h0001);
    poll(n);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_STAT, v);  chk("R1 status after reset", v, 16'h8080);
    rd(A_CODE, v);  chk("R1 code after reset", v, 16'h0000);
    rd(A_DATA, v);  chk("R1 data after reset", v, 16'h0000);
  endtask

  task automatic t_ident();
    logic [15:0] v;
    rd(A_SIG0, v); chk("R2 sig0", v, 16'h0043);
    rd(A_SIG1, v); chk("R2 sig1", v, 16'h004D);
    rd(A_SIG2, v); chk("R2 sig2", v, 16'h0044);
    rd(A_SIG3, v); chk("R2 sig3", v, 16'h0057);
    rd(A_MFR, v);  chk("R2 mfr", v, 16'h00A5);
    rd(A_DEV, v);  chk("R2 dev", v, 16'h5A17);
    rd(A_PBL, v);  chk("R2 pbuf loc", v, 16'h0400);
    rd(A_PBS, v);  chk("R2 pbuf size", v, 16'h0020);
    bus_addr = A_MFR; @(negedge clk);
    chk("R2 read data held without strobe", bus_rdata, 16'h0020);
  endtask

  task automatic t_cmdregs();
    logic [15:0] v;
    wr(A_CODE, 16'h1234); wr(A_DATA, 16'hBEEF); wr(A_ALO, 16'h5678);
    wr(A_AHI, 16'h9ABC); wr(A_CLO, 16'h0F0F); wr(A_CHI, 16'hF00D);
    rd(A_CODE, v); chk("R3 code", v, 16'h1234);
    rd(A_DATA, v); chk("R3 data", v, 16'hBEEF);
    rd(A_ALO, v);  chk("R3 addr lo", v, 16'h5678);
    rd(A_AHI, v);  chk("R3 addr hi", v, 16'h9ABC);
    rd(A_CLO, v);  chk("R3 count lo", v, 16'h0F0F);
    rd(A_CHI, v);  chk("R3 count hi", v, 16'hF00D);
  endtask

  task automatic t_clrbuf();
    logic [15:0] v;
    wr(A_CLRB, 16'h0002);
    rd(A_DATA, v); chk("R13 wrong value no clear", v, 16'hBEEF);
    wr(A_CLRB, 16'h0001);
    rd(A_DATA, v); chk("R13 data cleared", v, 16'h0000);
    rd(A_CLO, v);  chk("R13 count lo cleared", v, 16'h0000);
    rd(A_CHI, v);  chk("R13 count hi cleared", v, 16'h0000);
    rd(A_CODE, v); chk("R13 code kept", v, 16'h1234);
  endtask

  task automatic t_exec_timing();
    logic [15:0] v;
    int n;
    wr(A_ALO, 16'h0000); wr(A_AHI, 16'h0000);
    wr(A_CODE, 16'h0098); wr(A_EXEC, 16'h0002);
    rd(A_STAT, v); chk("R4 exec wrong value ignored", v, 16'h8080);
    wr(A_EXEC, 16'h0001);
    poll(n);
    chk("R4 busy cycles", 16'(n), 16'(B));
  endtask

  task automatic t_lock();
    logic [15:0] v;
    run_op(16'h0061, 16'h0000, 16'h0003);
    run_op(16'h0065, 16'h0000, 16'h0003);
    rd(A_DATA, v); chk("R6 block 3 locked", v, 16'h0001);
    run_op(16'h0065, 16'h0000, 16'h0004);
    rd(A_DATA, v); chk("R6 block 4 unlocked", v, 16'h0000);
    run_op(16'h0061, 16'h0000, 16'h0009);
    run_op(16'h0062, 16'h0000, 16'h0009);
    run_op(16'h0065, 16'h0000, 16'h0009);
    rd(A_DATA, v); chk("R6 block 9 unlocked again", v, 16'h0000);
  endtask

  task automatic t_locked_prog();
    logic [15:0] v;
    run_op(16'h0020, 16'h0000, 16'h0003);
    rd(A_STAT, v); chk("R7 erase on locked block", v, 16'h8082);
    wr(A_STAT, 16'h00C4);
    rd(A_STAT, v); chk("R12 read-only bits ignore write", v, 16'h8082);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, v); chk("R12 protect bit cleared", v, 16'h8080);
    run_op(16'h0041, 16'h0000, 16'h0004);
    rd(A_STAT, v); chk("R7 program on unlocked block clean", v, 16'h8080);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    wr(A_ALO, 16'h0000); wr(A_AHI, 16'h0003); wr(A_CODE, 16'h00E9);
    wr(A_EXEC, 16'h0001);
    repeat (B - 1) @(negedge clk);
    wr(A_STAT, 16'h0002);   // lands in the completion cycle
    rd(A_STAT, v); chk("R12 set wins over same-cycle clear", v, 16'h8082);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, v); chk("R12 later clear removes bit", v, 16'h8080);
  endtask

  task automatic t_exec_busy();
    logic [15:0] v;
    int n;
    wr(A_ALO, 16'h0000); wr(A_AHI, 16'h0005); wr(A_CODE, 16'h0020);
    wr(A_EXEC, 16'h0001);
    wr(A_CODE, 16'h0061); wr(A_EXEC, 16'h0001);
    poll(n);
    run_op(16'h0065, 16'h0000, 16'h0005);
    rd(A_DATA, v); chk("R5 lock while busy ignored", v, 16'h0000);
    rd(A_STAT, v); chk("R5 erase completed clean", v, 16'h8080);
  endtask

  task automatic t_invalid_half();
    logic [15:0] v;
    run_op(16'h0041, 16'h0001, 16'h0006);
    rd(A_STAT, v); chk("R8 odd word program", v, 16'h8380);
    wr(A_STAT, 16'h0100);
    rd(A_STAT, v); chk("R12 region code cleared by bit 8", v, 16'h8080);
  endtask

  task automatic t_unknown();
    logic [15:0] v;
    wr(A_ALO, 16'h0000); wr(A_CODE, 16'h0055); wr(A_EXEC, 16'h0001);
    rd(A_STAT, v); chk("R9 unknown code sets aux bit, no busy", v, 16'h9080);
    wr(A_STAT, 16'h1000);
    rd(A_STAT, v); chk("R12 aux cleared", v, 16'h8080);
  endtask

  task automatic t_suspend_prog();
    logic [15:0] v;
    int n;
    wr(A_ALO, 16'h0000); wr(A_AHI, 16'h0007); wr(A_CODE, 16'h00E9);
    wr(A_EXEC, 16'h0001);
    wr(A_SUSP, 16'h0001);                 // one countdown step consumed
    rd(A_STAT, v); chk("R10 program suspended", v, 16'h8084);
    wr(A_CODE, 16'h0020); wr(A_EXEC, 16'h0001);
    rd(A_STAT, v); chk("R5 exec while suspended ignored", v, 16'h8084);
    wr(A_CODE, 16'h00D0); wr(A_EXEC, 16'h0001);
    poll(n);
    chk("R11 remaining busy after resume", 16'(n), 16'(B - 1));
    rd(A_STAT, v); chk("R11 suspend cleared", v, 16'h8080);
  endtask

  task automatic t_suspend_erase();
    logic [15:0] v;
    int n;
    wr(A_AHI, 16'h0008); wr(A_CODE, 16'h0020); wr(A_EXEC, 16'h0001);
    wr(A_SUSP, 16'h0002);
    rd(A_STAT, v); chk("R10 suspend wrong value ignored", v, 16'h8000);
    wr(A_SUSP, 16'h0001);                 // third countdown step
    rd(A_STAT, v); chk("R10 erase suspended", v, 16'h80C0);
    wr(A_CODE, 16'h00D0); wr(A_EXEC, 16'h0001);
    poll(n);
    chk("R11 erase remaining busy", 16'(n), 16'(B - 3));
    wr(A_CODE, 16'h0098); wr(A_EXEC, 16'h0001);
    wr(A_SUSP, 16'h0001);
    rd(A_STAT, v); chk("R10 suspend during query ignored", v, 16'h8000);
    poll(n);
    wr(A_CODE, 16'h00D0); wr(A_EXEC, 16'h0001);
    rd(A_STAT, v); chk("R11 resume when idle no effect", v, 16'h8080);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ident();
    t_cmdregs();
    t_clrbuf();
    t_exec_timing();
    t_lock();
    t_locked_prog();
    t_collision();
    t_exec_busy();
    t_invalid_half();
    t_unknown();
    t_suspend_prog();
    t_suspend_erase();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule